// File: doc/BRIEF.md
# Integer Result Status Updater

This block sits at the end of a 32-bit integer execution stage. It takes two operands and an operation code for one of six operations: add, add with carry, AND, OR, XOR or NOT. It drives the result at once, without a clock edge in between. On the clock edge where the operation is valid, it also updates two architectural registers. The first is a fixed-point exception register that holds a sticky summary-overflow bit, an overflow bit and a carry bit. The second is a 32-bit condition register whose field 0 records how the signed result compares with zero.

Three enables come with each operation, one for each update: carry, overflow and the condition record. An update whose enable is clear leaves the bits it owns untouched. The summary-overflow bit is sticky. An overflow sets it, a later operation without overflow does not clear it, and only reset clears it. The condition record copies the summary-overflow bit as it stands after the same operation's overflow update.

Top module: `int_status_unit`

## Requirements
- R1: `result` follows the inputs without a clock edge. The `opSel` codes are: 0 gives srcA+srcB, 1 gives srcA+srcB+CA, 2 gives srcA AND srcB, 3 gives srcA OR srcB, 4 gives srcA XOR srcB, 5 gives NOT srcA, and 6 and 7 give zero. Every sum is taken modulo 2^32.
- R2: Bit positions below use LSB-0 numbering. SO is `xerOut[31]`, OV is `xerOut[30]` and CA is `xerOut[29]`. On a valid operation with `carryEn` high, CA takes the carry out of the unsigned 33-bit sum. For codes 2 to 7, CA takes 0.
- R3: On a valid operation with `carryEn` low, CA keeps its value.
- R4: On a valid operation with `ovEn` high and signed two's-complement overflow, both OV and SO become 1. Codes 2 to 7 never overflow.
- R5: On a valid operation with `ovEn` high and no overflow, OV becomes 0 and SO keeps its value.
- R6: On a valid operation with `ovEn` low, OV and SO keep their values.
- R7: Code 1 uses the CA value held before the operation as its carry-in, for the result, for the carry and for the overflow.
- R8: On a valid operation with `recordEn` high, `crOut[31:28]` becomes {LT, GT, EQ, SO}. LT, GT and EQ come from the signed result compared with zero, so exactly one of them is 1. SO is the value after this operation's overflow update.
- R9: On a valid operation with `recordEn` low, `crOut` keeps its value.
- R10: When `opValid` is low, neither register changes.
- R11: Synchronous reset (`rst` high at a rising edge) clears both registers. Every register bit not named above always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opValid | input | 1 | Operation present this cycle |
| opSel | input | 3 | Operation code (see R1) |
| srcA | input | 32 | First operand |
| srcB | input | 32 | Second operand |
| carryEn | input | 1 | Write CA |
| ovEn | input | 1 | Write OV and possibly SO |
| recordEn | input | 1 | Write condition field 0 |
| result | output | 32 | Operation result |
| xerOut | output | 32 | Fixed-point exception register |
| crOut | output | 32 | Condition register |

## Verification
The bench uses directed operand pairs at the signed and unsigned limits: 0x7FFFFFFF+1, 0xFFFFFFFF+1, 0x80000000+0x80000000 and sums that are exactly zero. These separate carry-out from signed overflow, because each flag can appear without the other. Chains of add-with-carry show that the carry-in is the old CA, not the CA being written. An overflow followed by a clean add with the overflow enable set shows that SO is sticky while OV clears. Runs with random operands, operation codes, enables and idle cycles cover every combination of gated updates, including condition records taken on the same edge that first sets SO.

// File: rtl/isu_pkg.sv
package isu_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADDC = 3'd1,
    OP_AND  = 3'd2,
    OP_OR   = 3'd3,
    OP_XOR  = 3'd4,
    OP_NOT  = 3'd5
  } opCode_e;

  typedef enum logic [2:0] {
    RES_SUM,
    RES_AND,
    RES_OR,
    RES_XOR,
    RES_NOT,
    RES_ZERO
  } resSel_e;

  typedef struct packed {
    logic    writeCarry;
    logic    writeOverflow;
    logic    writeRecord;
    logic    isArith;
    logic    useCarryIn;
    resSel_e resSel;
  } strobe_t;

endpackage

// File: rtl/isu_control.sv
module isu_control
  import isu_pkg::*;
(
  input  logic       opValid,
  input  logic [2:0] opSel,
  input  logic       carryEn,
  input  logic       ovEn,
  input  logic       recordEn,
  output strobe_t    strobe
);

  always_comb begin
    strobe               = '0;
    strobe.resSel        = RES_ZERO;
    strobe.writeCarry    = opValid && carryEn;
    strobe.writeOverflow = opValid && ovEn;
    strobe.writeRecord   = opValid && recordEn;
    unique case (opSel)
      OP_ADD: begin
        strobe.isArith = 1'b1;
        strobe.resSel  = RES_SUM;
      end
      OP_ADDC: begin
        strobe.isArith    = 1'b1;
        strobe.useCarryIn = 1'b1;
        strobe.resSel     = RES_SUM;
      end
      OP_AND:  strobe.resSel = RES_AND;
      OP_OR:   strobe.resSel = RES_OR;
      OP_XOR:  strobe.resSel = RES_XOR;
      OP_NOT:  strobe.resSel = RES_NOT;
      default: strobe.resSel = RES_ZERO;
    endcase
  end

endmodule

// File: rtl/isu_datapath.sv
module isu_datapath
  import isu_pkg::*;
#(
  parameter int W        = 32,
  parameter int FIELD_W  = 4,
  parameter int REC_FIELD = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  strobe_t      strobe,
  input  logic [W-1:0] srcA,
  input  logic [W-1:0] srcB,
  output logic [W-1:0] result,
  output logic [W-1:0] xerOut,
  output logic [W-1:0] crOut
);

  localparam int SO_POS    = W - 1;
  localparam int OV_POS    = W - 2;
  localparam int CA_POS    = W - 3;
  localparam int N_FIELDS  = W / FIELD_W;

  logic         soQ, ovQ, caQ;
  logic [W-1:0] crQ;

  // widened sums: zero-extended for carry, sign-extended for overflow
  logic         carryIn;
  logic [W:0]   unsignedSum;
  logic [W:0]   signedSum;
  logic         carryOut;
  logic         overflow;

  assign carryIn     = strobe.useCarryIn & caQ;
  assign unsignedSum = {1'b0, srcA} + {1'b0, srcB} + {{W{1'b0}}, carryIn};
  assign signedSum   = {srcA[W-1], srcA} + {srcB[W-1], srcB} + {{W{1'b0}}, carryIn};
  assign carryOut    = strobe.isArith & unsignedSum[W];
  assign overflow    = strobe.isArith & (signedSum[W] ^ signedSum[W-1]);

  always_comb begin
    unique case (strobe.resSel)
      RES_SUM: result = unsignedSum[W-1:0];
      RES_AND: result = srcA & srcB;
      RES_OR:  result = srcA | srcB;
      RES_XOR: result = srcA ^ srcB;
      RES_NOT: result = ~srcA;
      default: result = '0;
    endcase
  end

  // next flag values
  logic soNext, ovNext, caNext;

  always_comb begin
    soNext = soQ;
    ovNext = ovQ;
    caNext = caQ;
    if (strobe.writeOverflow) begin
      ovNext = overflow;
      soNext = soQ | overflow;
    end
    if (strobe.writeCarry) caNext = carryOut;
  end

  // compare field: LT, GT, EQ, SO from the most significant bit down
  logic [FIELD_W-1:0] recField;
  logic               isNeg, isZero;

  assign isNeg    = result[W-1];
  assign isZero   = (result == '0);
  assign recField = {isNeg, !isNeg && !isZero, isZero, soNext};

  logic [W-1:0] crNext;

  for (genvar f = 0; f < N_FIELDS; f++) begin : g_field
    localparam int HI = W - 1 - f * FIELD_W;
    if (f == REC_FIELD) begin : g_rec
      assign crNext[HI -: FIELD_W] = strobe.writeRecord ? recField : crQ[HI -: FIELD_W];
    end else begin : g_keep
      assign crNext[HI -: FIELD_W] = crQ[HI -: FIELD_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      soQ <= 1'b0;
      ovQ <= 1'b0;
      caQ <= 1'b0;
      crQ <= '0;
    end else begin
      soQ <= soNext;
      ovQ <= ovNext;
      caQ <= caNext;
      crQ <= crNext;
    end
  end

  always_comb begin
    xerOut         = '0;
    xerOut[SO_POS] = soQ;
    xerOut[OV_POS] = ovQ;
    xerOut[CA_POS] = caQ;
  end

  assign crOut = crQ;

endmodule

// File: rtl/int_status_unit.sv
module int_status_unit
  import isu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         opValid,
  input  logic [2:0]   opSel,
  input  logic [W-1:0] srcA,
  input  logic [W-1:0] srcB,
  input  logic         carryEn,
  input  logic         ovEn,
  input  logic         recordEn,
  output logic [W-1:0] result,
  output logic [W-1:0] xerOut,
  output logic [W-1:0] crOut
);

  strobe_t strobe;

  isu_control u_ctrl (
    .opValid  (opValid),
    .opSel    (opSel),
    .carryEn  (carryEn),
    .ovEn     (ovEn),
    .recordEn (recordEn),
    .strobe   (strobe)
  );

  isu_datapath #(.W(W)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .srcA   (srcA),
    .srcB   (srcB),
    .result (result),
    .xerOut (xerOut),
    .crOut  (crOut)
  );

endmodule

// File: rtl/isu_checker.sv
module isu_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         opValid,
  input logic [2:0]   opSel,
  input logic         carryEn,
  input logic         ovEn,
  input logic         recordEn,
  input logic [W-1:0] xerOut,
  input logic [W-1:0] crOut
);

  localparam int SO = W - 1;
  localparam int OV = W - 2;
  localparam int CA = W - 3;

  logic isLogic;
  assign isLogic = opSel > 3'd1;

  assert_carry_hold_R3: assert property (@(posedge clk) disable iff (rst)
    opValid && !carryEn |=> $stable(xerOut[CA]));

  assert_logic_no_carry_R2: assert property (@(posedge clk) disable iff (rst)
    opValid && carryEn && isLogic |=> !xerOut[CA]);

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    opValid && ovEn && isLogic |=> !xerOut[OV]);

  assert_ov_implies_so_R4: assert property (@(posedge clk) disable iff (rst)
    xerOut[OV] |-> xerOut[SO]);

  assert_so_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    xerOut[SO] |=> xerOut[SO]);

  assert_ov_hold_R6: assert property (@(posedge clk) disable iff (rst)
    opValid && !ovEn |=> $stable(xerOut[SO]) && $stable(xerOut[OV]));

  assert_record_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    opValid && recordEn |=> $countones(crOut[W-1:W-3]) == 1 && crOut[W-4] == xerOut[SO]);

  assert_cr_hold_R9: assert property (@(posedge clk) disable iff (rst)
    opValid && !recordEn |=> $stable(crOut));

  assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !opValid |=> $stable(crOut) && $stable(xerOut));

  assert_unused_zero_R11: assert property (@(posedge clk) disable iff (rst)
    xerOut[W-4:0] == '0 && crOut[W-5:0] == '0);

endmodule

bind int_status_unit isu_checker #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .opValid  (opValid),
  .opSel    (opSel),
  .carryEn  (carryEn),
  .ovEn     (ovEn),
  .recordEn (recordEn),
  .xerOut   (xerOut),
  .crOut    (crOut)
);

// File: tb/tb_int_status_unit.sv
module tb_int_status_unit;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        opValid = 1'b0;
  logic [2:0]  opSel = '0;
  logic [31:0] srcA = '0, srcB = '0;
  logic        carryEn = 1'b0, ovEn = 1'b0, recordEn = 1'b0;
  logic [31:0] result, xerOut, crOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference state
  logic [31:0] xerM = '0;
  logic [31:0] crM  = '0;
  string       regTag = "R11";

  always #(CLK_PERIOD/2) clk = ~clk;

  int_status_unit dut (
    .clk(clk), .rst(rst), .opValid(opValid), .opSel(opSel),
    .srcA(srcA), .srcB(srcB), .carryEn(carryEn), .ovEn(ovEn),
    .recordEn(recordEn), .result(result), .xerOut(xerOut), .crOut(crOut)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // apply one cycle of stimulus and predict the state after the next edge
  task automatic step(bit v, logic [2:0] op, logic [31:0] a, logic [31:0] b,
                      bit ce, bit oe, bit re, bit rs);
    longint      ua, ub, ci, us;
    longint      sa, sb, ss;
    logic [31:0] res;
    bit          cy, ov, so;
    @(negedge clk);
    check({regTag, " xer"}, xerOut, xerM);
    check({regTag, " cr"}, crOut, crM);
    rst = rs; opValid = v; opSel = op; srcA = a; srcB = b;
    carryEn = ce; ovEn = oe; recordEn = re;
    ci = (op == 3'd1) ? longint'(xerM[29]) : 0;
    ua = longint'(a); ub = longint'(b);
    sa = longint'($signed(a)); sb = longint'($signed(b));
    us = ua + ub + ci;
    ss = sa + sb + ci;
    cy = 1'b0; ov = 1'b0;
    case (op)
      3'd0, 3'd1: begin
        res = us[31:0];
        cy  = us[32];
        ov  = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
      end
      3'd2: res = a & b;
      3'd3: res = a | b;
      3'd4: res = a ^ b;
      3'd5: res = ~a;
      default: res = '0;
    endcase
    #1;
    check((op == 3'd1) ? "R1 R7 result" : "R1 result", result, res);
    if (rs) begin
      xerM = '0; crM = '0; regTag = "R11";
    end else if (!v) begin
      regTag = "R10";
    end else begin
      regTag = (op == 3'd1) ? "R2 R3 R4 R5 R6 R7 R8 R9" : "R2 R3 R4 R5 R6 R8 R9";
      if (oe) begin
        xerM[30] = ov;
        if (ov) xerM[31] = 1'b1;
      end
      if (ce) xerM[29] = cy;
      if (re) begin
        so = xerM[31];
        crM[31:28] = {res[31], !res[31] && res != 0, res == 0, so};
      end
    end
  endtask

  initial begin
    step(0, 0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 0, 0);  // R11 reset state checked next
    // R2 carry without signed overflow, R8 zero record
    step(1, 0, 32'hFFFF_FFFF, 32'h1, 1, 1, 1, 0);
    // R7 add-with-carry consumes CA=1
    step(1, 1, 32'h0000_0010, 32'h0000_0020, 1, 0, 1, 0);
    // R4 signed overflow without carry, record sees new SO
    step(1, 0, 32'h7FFF_FFFF, 32'h1, 1, 1, 1, 0);
    // R5 clean add clears OV only, SO stays
    step(1, 0, 32'h5, 32'h6, 1, 1, 1, 0);
    // R4 overflow with carry
    step(1, 0, 32'h8000_0000, 32'h8000_0000, 1, 1, 1, 0);
    // R3 carry held, R6 overflow held, R9 record held
    step(1, 0, 32'h1, 32'h1, 0, 0, 0, 0);
    // R7 chain with CA=1: 0xFFFFFFFF + 0 + 1 carries again
    step(1, 1, 32'hFFFF_FFFF, 32'h0, 1, 1, 1, 0);
    // R10 idle cycle with all enables up
    step(0, 0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1, 1, 1, 0);
    // R1 logic ops, R2 logic clears CA, R8 negative record
    step(1, 2, 32'hF0F0_F0F0, 32'hFF00_FF00, 1, 1, 1, 0);
    step(1, 3, 32'h0000_0000, 32'h0000_0000, 1, 1, 1, 0);
    step(1, 4, 32'h1234_5678, 32'h1234_5678, 1, 1, 1, 0);
    step(1, 5, 32'h8000_0000, 32'h0, 0, 0, 1, 0);
    step(1, 6, 32'h1234_5678, 32'h9ABC_DEF0, 1, 1, 1, 0);
    // R11 reset mid-run clears sticky SO
    step(1, 0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1, 1, 1, 1);
    step(1, 0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1, 1, 1, 0);
    // random sweep
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] ra, rb;
      logic [3:0]  sel;
      ra  = $urandom();
      rb  = $urandom();
      sel = 4'($urandom_range(0, 15));
      if (sel[3]) ra = {sel[0], 31'h7FFF_FFF0 | 31'($urandom_range(0, 15))};
      step($urandom_range(0, 9) != 0, 3'($urandom_range(0, 7)), ra, rb,
           1'($urandom), 1'($urandom), 1'($urandom), $urandom_range(0, 199) == 0);
    end
    step(0, 0, 0, 0, 0, 0, 0, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule